// File: doc/BRIEF.md
# SD Card SPI Command Framer and Response Poller

This block issues a single command to an SD card running in SPI mode and collects the card's answer. A controller supplies a 6-bit command index, a 32-bit argument and the check byte to send, then pulses `start`. The block lowers chip select, spends one filler byte slot with the card selected, and shifts out the six-byte command frame. It then keeps clocking 0xFF filler bytes until the card returns a byte whose top bit is clear. That byte is the one-byte status response. The status bits, counted upward from bit 0, flag idle, erase reset, illegal command, command check error, erase sequence error, address error and parameter error. Bit 7 is always zero.

Some commands return a 32-bit trailer after the status byte, such as the interface condition query and the operating condition read. For these, the controller sets `long_rsp` and the block collects four more bytes. Normally the block then raises chip select and clocks one last 0xFF byte, so the card releases its data output. A command that is followed by a data block sets `hold_cs` instead, and the block finishes with chip select still low. Bytes move through an external byte-wide SPI shifter using a go/acknowledge handshake. Only one byte is ever outstanding.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: After reset, `cs_n` is 1, `byte_go`, `done` and `busy` are 0, and `r1` reads 0xFF.
- R2: After `start`, `cs_n` goes low together with a first byte slot carrying 0xFF. The next five bytes sent are `{2'b01, cmd_idx}` followed by `cmd_arg` split into bytes, most significant byte first.
- R3: The seventh byte sent (the sixth frame byte) is `crc_in` unchanged. For example, 0x87 is sent for the interface condition query and 0x95 for other commands.
- R4: After the frame, every byte sent is 0xFF until a received byte has bit 7 clear. That byte is stored in `r1`. Received bytes with bit 7 set are skipped, including values other than 0xFF.
- R5: If POLL_LIMIT (5000) polled bytes all have bit 7 set, the block raises `timeout`, leaves `r1` at 0xFF and releases the card. A response arriving on the 5000th poll is accepted without timeout.
- R6: With `long_rsp` = 1, exactly four more bytes are exchanged after `r1` and placed in `extra`, the first received byte in bits 31:24. With `long_rsp` = 0, no extra bytes are exchanged and `extra` reads 0.
- R7: Unless the card is kept selected, the block raises `cs_n` and then sends exactly one 0xFF byte with `cs_n` high before `done` pulses.
- R8: With `hold_cs` = 1 and a valid response, `done` pulses with `cs_n` still low and no trailing byte. A timeout always releases `cs_n`, whatever `hold_cs` is.
- R9: A new `byte_go` is issued only after the previous byte's `byte_ack`. `done` is a single-cycle pulse. `busy` is high from the cycle after `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (sampled while idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| crc_in | input | 8 | Final frame byte, sent as given |
| long_rsp | input | 1 | 1: collect four bytes after the status byte |
| hold_cs | input | 1 | 1: finish with chip select still asserted |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No response within the poll limit |
| r1 | output | 8 | Captured status byte |
| extra | output | 32 | Captured trailing word |
| cs_n | output | 1 | Card chip select, active low |
| byte_go | output | 1 | Request one byte exchange |
| byte_tx | output | 8 | Byte to shift out |
| byte_ack | input | 1 | Byte exchange complete |
| byte_rx | input | 8 | Byte shifted in |

## Verification
Every result comes from a register that is updated on the edge that samples the final `byte_ack` of a command. `done`, `r1`, `extra`, `timeout` and the final `cs_n` level therefore all appear together one cycle after that acknowledge. The bench waits for `done` at falling edges and reads every result in that same cycle. The frame bytes and chip-select levels are logged by the bench's shifter model on the edge where it sees `byte_go`. `busy`, `cs_n` and the first 0xFF slot are checked one cycle after `start`, which is the first cycle in which they can change.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_FRAME,
    ST_POLL,
    ST_EXTRA,
    ST_TAIL
  } sdspi_state_e;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam int         FRAME_BYTES = 6;
  localparam logic [1:0] FRAME_HEAD  = 2'b01;
endpackage

// File: rtl/sdspi_frame_sel.sv
module sdspi_frame_sel
  import sdspi_pkg::*;
#(
  parameter int SLOT_W = 3
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [5:0]        cmd,
  input  logic [31:0]       arg,
  input  logic [7:0]        crc,
  output logic [7:0]        frame_byte
);
  always_comb begin
    case (slot)
      SLOT_W'(0): frame_byte = {FRAME_HEAD, cmd};
      SLOT_W'(1): frame_byte = arg[31:24];
      SLOT_W'(2): frame_byte = arg[23:16];
      SLOT_W'(3): frame_byte = arg[15:8];
      SLOT_W'(4): frame_byte = arg[7:0];
      SLOT_W'(5): frame_byte = crc;
      default:    frame_byte = FILL_BYTE;
    endcase
  end
endmodule

// File: rtl/sdspi_poll_ctr.sv
module sdspi_poll_ctr #(
  parameter  int LIMIT = 5000,
  localparam int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/sdspi_rsp_shift.sv
module sdspi_rsp_shift #(
  parameter  int NBYTES = 4,
  localparam int W      = NBYTES * 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic [7:0]   din,
  output logic [W-1:0] word
);
  generate
    if (NBYTES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst || clr) word <= '0;
        else if (shift) word <= {word[W-9:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clr) word <= '0;
        else if (shift) word <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
  import sdspi_pkg::*;
#(
  parameter  int POLL_LIMIT  = 5000,
  parameter  int EXTRA_BYTES = 4,
  localparam int EXW         = EXTRA_BYTES * 8,
  localparam int EIDX_W      = $clog2(EXTRA_BYTES + 1),
  localparam int SLOT_W      = $clog2(FRAME_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [5:0]     cmd_idx,
  input  logic [31:0]    cmd_arg,
  input  logic [7:0]     crc_in,
  input  logic           long_rsp,
  input  logic           hold_cs,
  output logic           busy,
  output logic           done,
  output logic           timeout,
  output logic [7:0]     r1,
  output logic [EXW-1:0] extra,
  output logic           cs_n,
  output logic           byte_go,
  output logic [7:0]     byte_tx,
  input  logic           byte_ack,
  input  logic [7:0]     byte_rx
);
  sdspi_state_e      st;
  logic [SLOT_W-1:0] slot;
  logic [EIDX_W-1:0] eidx;
  logic [5:0]        cmd_q;
  logic [31:0]       arg_q;
  logic [7:0]        crc_q;
  logic              long_q, hold_q;
  logic [7:0]        frame_byte;
  logic              poll_last;

  // Event decode for the current acknowledge
  logic rsp_ok, poll_to, ext_end, finish_ok, go_release, go_hold_done;
  logic poll_clr, poll_inc, ext_clr, ext_shift;

  assign rsp_ok       = (st == ST_POLL) && byte_ack && !byte_rx[7];
  assign poll_to      = (st == ST_POLL) && byte_ack && byte_rx[7] && poll_last;
  assign ext_end      = (st == ST_EXTRA) && byte_ack && (eidx == EIDX_W'(EXTRA_BYTES - 1));
  assign finish_ok    = (rsp_ok && !long_q) || ext_end;
  assign go_release   = (finish_ok && !hold_q) || poll_to;
  assign go_hold_done = finish_ok && hold_q;

  assign poll_clr  = (st == ST_FRAME) && byte_ack && (slot == SLOT_W'(FRAME_BYTES));
  assign poll_inc  = (st == ST_POLL) && byte_ack;
  assign ext_clr   = (st == ST_IDLE) && start;
  assign ext_shift = (st == ST_EXTRA) && byte_ack;

  sdspi_frame_sel #(.SLOT_W(SLOT_W)) frame_i (
    .slot       (slot),
    .cmd        (cmd_q),
    .arg        (arg_q),
    .crc        (crc_q),
    .frame_byte (frame_byte)
  );

  sdspi_poll_ctr #(.LIMIT(POLL_LIMIT)) poll_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (poll_clr),
    .inc  (poll_inc),
    .last (poll_last)
  );

  sdspi_rsp_shift #(.NBYTES(EXTRA_BYTES)) shift_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (ext_clr),
    .shift (ext_shift),
    .din   (byte_rx),
    .word  (extra)
  );

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      slot    <= '0;
      eidx    <= '0;
      cmd_q   <= '0;
      arg_q   <= '0;
      crc_q   <= '0;
      long_q  <= 1'b0;
      hold_q  <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      r1      <= FILL_BYTE;
      cs_n    <= 1'b1;
      byte_go <= 1'b0;
      byte_tx <= FILL_BYTE;
    end else begin
      byte_go <= 1'b0;
      done    <= 1'b0;
      if (rsp_ok)  r1      <= byte_rx;
      if (poll_to) timeout <= 1'b1;

      if (go_release) begin
        cs_n    <= 1'b1;
        byte_tx <= FILL_BYTE;
        byte_go <= 1'b1;
        st      <= ST_TAIL;
      end else if (go_hold_done) begin
        done <= 1'b1;
        st   <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            cmd_q   <= cmd_idx;
            arg_q   <= cmd_arg;
            crc_q   <= crc_in;
            long_q  <= long_rsp;
            hold_q  <= hold_cs;
            r1      <= FILL_BYTE;
            timeout <= 1'b0;
            slot    <= '0;
            cs_n    <= 1'b0;
            byte_tx <= FILL_BYTE;
            byte_go <= 1'b1;
            st      <= ST_LEAD;
          end
          ST_LEAD: if (byte_ack) begin
            byte_tx <= frame_byte;
            byte_go <= 1'b1;
            slot    <= slot + 1'b1;
            st      <= ST_FRAME;
          end
          ST_FRAME: if (byte_ack) begin
            byte_go <= 1'b1;
            if (slot == SLOT_W'(FRAME_BYTES)) begin
              byte_tx <= FILL_BYTE;
              st      <= ST_POLL;
            end else begin
              byte_tx <= frame_byte;
              slot    <= slot + 1'b1;
            end
          end
          ST_POLL: if (byte_ack) begin
            byte_tx <= FILL_BYTE;
            byte_go <= 1'b1;
            eidx    <= '0;
            if (!byte_rx[7]) st <= ST_EXTRA;
          end
          ST_EXTRA: if (byte_ack) begin
            byte_tx <= FILL_BYTE;
            byte_go <= 1'b1;
            eidx    <= eidx + 1'b1;
          end
          ST_TAIL: if (byte_ack) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdspi_cmd_engine_chk.sv
module sdspi_cmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       byte_go,
  input logic [7:0] byte_tx,
  input logic       byte_ack,
  input logic       done,
  input logic       timeout,
  input logic [7:0] r1
);
  logic inflight;

  always_ff @(posedge clk) begin
    if (rst)           inflight <= 1'b0;
    else if (byte_go)  inflight <= 1'b1;
    else if (byte_ack) inflight <= 1'b0;
  end

  assert_one_inflight_R9: assert property (@(posedge clk) disable iff (rst)
    byte_go |-> !inflight);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_lead_slot_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (byte_go && byte_tx == 8'hFF));

  assert_tail_byte_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (byte_go && byte_tx == 8'hFF));

  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (rst)
    (done && timeout) |-> cs_n);

  assert_r1_msb_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !timeout) |-> !r1[7]);
endmodule

bind sdspi_cmd_engine sdspi_cmd_engine_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .byte_go  (byte_go),
  .byte_tx  (byte_tx),
  .byte_ack (byte_ack),
  .done     (done),
  .timeout  (timeout),
  .r1       (r1)
);

// File: tb/sdspi_cmd_engine_tb_top.sv
module sdspi_cmd_engine_tb_top;
  localparam int LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  crc_in = 8'h95;
  logic        long_rsp = 1'b0;
  logic        hold_cs = 1'b0;
  logic        busy, done, timeout, cs_n, byte_go;
  logic [7:0]  r1, byte_tx;
  logic [31:0] extra;
  logic        byte_ack = 1'b0;
  logic [7:0]  byte_rx = 8'hFF;

  always #2 clk = ~clk;

  sdspi_cmd_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .crc_in(crc_in), .long_rsp(long_rsp), .hold_cs(hold_cs), .busy(busy),
    .done(done), .timeout(timeout), .r1(r1), .extra(extra), .cs_n(cs_n),
    .byte_go(byte_go), .byte_tx(byte_tx), .byte_ack(byte_ack), .byte_rx(byte_rx)
  );

  // Card and shifter model configuration (driven only by the main initial)
  int          cfg_delay = 0;
  logic [7:0]  cfg_r1 = 8'h00;
  logic [31:0] cfg_ext = '0;
  logic        cfg_long = 1'b0;

  // Model state
  int         slot_n = 0;
  int         pend = 0;
  int         hi_cnt = 0;
  logic       overlap = 1'b0;
  logic       last_cs = 1'b1;
  logic [7:0] last_tx = 8'h00;
  logic [7:0] rx_hold = 8'hFF;
  logic [7:0] tx_log [16];
  logic       cs_log [16];

  function automatic logic [7:0] rx_for(int s);
    int j;
    if (s < 7) return 8'hFF;
    j = s - 7;
    if (j < cfg_delay) return 8'h80 | 8'(j & 32'h7F);
    if (j == cfg_delay) return cfg_r1;
    if (cfg_long && j <= cfg_delay + 4)
      return 8'(cfg_ext >> (8 * (3 - (j - cfg_delay - 1))));
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    byte_ack <= 1'b0;
    if (start) begin
      slot_n  <= 0;
      hi_cnt  <= 0;
      overlap <= 1'b0;
    end
    if (byte_go) begin
      if (pend != 0) overlap <= 1'b1;
      if (slot_n < 16) begin
        tx_log[slot_n] <= byte_tx;
        cs_log[slot_n] <= cs_n;
      end
      if (cs_n) hi_cnt <= hi_cnt + 1;
      last_tx <= byte_tx;
      last_cs <= cs_n;
      rx_hold <= rx_for(slot_n);
      slot_n  <= slot_n + 1;
      pend    <= 2;
    end else if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        byte_ack <= 1'b1;
        byte_rx  <= rx_hold;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input bit lg,
                         input bit hd, input int dly, input logic [7:0] rv,
                         input logic [31:0] ev);
    int  wait_n;
    bit  to_exp;
    int  polls;
    int  slots_exp;
    bit  released;
    logic [7:0] crc_exp;
    to_exp    = (dly >= LIMIT);
    polls     = to_exp ? LIMIT : dly + 1;
    released  = to_exp || !hd;
    slots_exp = 7 + polls + ((lg && !to_exp) ? 4 : 0) + (released ? 1 : 0);
    crc_exp   = (c == 6'd8) ? 8'h87 : 8'h95;
    @(negedge clk);
    cfg_delay = dly; cfg_r1 = rv; cfg_ext = ev; cfg_long = lg;
    cmd_idx = c; cmd_arg = a; crc_in = crc_exp; long_rsp = lg; hold_cs = hd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", 32'(busy), 32'd1);
    chk(cs_n == 1'b0 && byte_go && byte_tx == 8'hFF, "R2 lead slot",
        {cs_n, byte_go, byte_tx}, {1'b0, 1'b1, 8'hFF});
    wait_n = 0;
    while (!done && wait_n < 30000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1, "R9 done reached (watchdog)", 32'(done), 32'd1);
    chk(tx_log[1] == {2'b01, c}, "R2 command byte", 32'(tx_log[1]), {24'd0, 2'b01, c});
    chk({tx_log[2], tx_log[3], tx_log[4], tx_log[5]} == a, "R2 argument MSB first",
        {tx_log[2], tx_log[3], tx_log[4], tx_log[5]}, a);
    chk(cs_log[0] == 1'b0 && cs_log[6] == 1'b0, "R2 cs low through frame",
        {cs_log[0], cs_log[6]}, 32'd0);
    chk(tx_log[6] == crc_exp, "R3 check byte", 32'(tx_log[6]), 32'(crc_exp));
    chk(tx_log[7] == 8'hFF && tx_log[8] == 8'hFF, "R4 poll filler",
        {tx_log[7], tx_log[8]}, 32'hFFFF);
    chk(r1 == (to_exp ? 8'hFF : rv), "R4 R5 captured status", 32'(r1),
        32'(to_exp ? 8'hFF : rv));
    chk(timeout == to_exp, "R5 timeout flag", 32'(timeout), 32'(to_exp));
    chk(extra == ((lg && !to_exp) ? ev : 32'd0), "R6 trailing word", extra,
        (lg && !to_exp) ? ev : 32'd0);
    chk(slot_n == slots_exp, "R6 R7 R8 byte count", 32'(slot_n), 32'(slots_exp));
    chk(hi_cnt == (released ? 1 : 0), "R7 bytes with cs high", 32'(hi_cnt),
        released ? 32'd1 : 32'd0);
    if (released)
      chk(last_cs == 1'b1 && last_tx == 8'hFF, "R7 trailing 0xFF with cs high",
          {last_cs, last_tx}, {1'b1, 8'hFF});
    chk(cs_n == released, "R8 cs level at done", 32'(cs_n), 32'(released));
    chk(overlap == 1'b0, "R9 one byte in flight", 32'(overlap), 32'd0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done single pulse", {done, busy}, 32'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected<190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int dl [3];
    dl[0] = 0; dl[1] = 2; dl[2] = 6;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && byte_go == 1'b0 && done == 1'b0 && busy == 1'b0,
        "R1 reset outputs", {cs_n, byte_go, done, busy}, 32'h8);
    chk(r1 == 8'hFF, "R1 reset status", 32'(r1), 32'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && byte_go == 1'b0, "R1 idle after reset", {cs_n, byte_go}, 32'h2);
    for (int lg = 0; lg < 2; lg++) begin
      for (int hd = 0; hd < 2; hd++) begin
        for (int d = 0; d < 3; d++) begin
          int k;
          logic [5:0] c;
          k = lg * 6 + hd * 3 + d;
          c = (k == 4) ? 6'd8 : 6'((k * 13 + 17) % 64);
          run_cmd(c, 32'h1357_9BDF ^ (32'(k) << 27) ^ 32'(k * 77),
                  lg[0], hd[0], dl[d], 8'(k % 8) & 8'h7F,
                  32'hC0DE_0000 | 32'(k * 4099));
        end
      end
    end
    run_cmd(6'd58, 32'h0, 1'b1, 1'b1, 3, 8'h7F, 32'h80FF_00AA);
    run_cmd(6'd17, 32'hDEAD_BEEF, 1'b0, 1'b0, LIMIT - 1, 8'h04, 32'h0);
    run_cmd(6'd0, 32'h0, 1'b1, 1'b1, 100000, 8'h01, 32'h1234_5678);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule